// File: doc/BRIEF.md
# PCI bus parity generator and checker

This block produces and checks the even parity bit that accompanies the 32-bit multiplexed address/data bus and the 4-bit command/byte-enable bus of a PCI agent. Each clock it folds the 36 bus bits into one parity bit and registers it. The result is presented on the parity output one clock later, which is exactly when the bus expects PAR for the data seen in the previous clock.

A small phase tracker follows FRAME#, IRDY#, TRDY# and STOP#. It marks the address phase, latches the transfer direction from the command, and notes when the last data phase completes. With two role inputs, which say whether the local agent owns the transaction as master or has claimed it as target, the block decides two things each clock. It decides whether the local agent is driving AD, in which case the parity output enable is raised in the following clock. It also decides whether the incoming AD carries valid data from another agent, in which case the PAR received one clock later is compared with the registered parity. A mismatch raises a one-clock pulse on an address or a data parity error output. What is done with those pulses, and the pad drivers, belong to the logic around the block.

Top module: `pcipar_top`

## Requirements
- R1: `par_o` in every clock equals the XOR of the 32 AD bits and the 4 C/BE# bits sampled at the previous rising edge, so that those 36 bits plus `par_o` hold an even number of ones.
- R2: An address phase is the first clock with FRAME# low after the bus was idle (no transaction in progress, or the previous one ended with a completed final data phase or with FRAME# and IRDY# both high). In the address phase, C/BE#[0] high marks a write and low marks a read for the rest of the transaction. Address phases are recognised back to back, directly after a final data phase.
- R3: `par_oe_o` is high in a clock exactly when the local agent drove AD in the previous clock. The agent drives AD as master in the address phase and in the data phases of a write, and as target in the data phases of a read.
- R4: The final data phase completes in a clock with FRAME# high, IRDY# low and either TRDY# or STOP# low. `par_oe_o` stays high for the one clock after that completion and is low in the clock after that. It is never high in the clock after a clock in which FRAME# and IRDY# were both high.
- R5: When the local agent is not the master (`mst_own_i` low), the PAR received in the clock after an address phase is compared with the parity of that address phase. A mismatch raises `addr_perr_o` for one clock, in the clock after the PAR was received.
- R6: As target of a write, data is checked in each data-phase clock with IRDY# low. As master of a read, data is checked in each data-phase clock with TRDY# low. The PAR received one clock later is compared with that data's parity, and a mismatch raises `data_perr_o` for one clock, two clocks after the data clock.
- R7: No parity error is reported for data the local agent drove itself, for data phases of a transaction it neither owns nor claims, or for data clocks where the sender's ready signal (IRDY# on a write, TRDY# on a read) is high.
- R8: While `rst_n` is low at a rising edge, the registered parity, the output enable, both error pulses and the phase state are cleared. The first clock with FRAME# low after reset is taken as an address phase.
- R9: An error pulse never lasts more than one clock for a single mismatching address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ad_i | input | AD_W (32) | Address/data bus as seen on the pins |
| cbe_n_i | input | BE_W (4) | Command / byte enable bus, active low |
| frame_n_i | input | 1 | Cycle frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| stop_n_i | input | 1 | Target stop request, active low |
| mst_own_i | input | 1 | Local agent is master of the current transaction |
| tgt_sel_i | input | 1 | Local agent has claimed the current transaction as target |
| par_i | input | 1 | PAR as received from the bus |
| par_o | output | 1 | Generated even parity, one clock after the bus bits |
| par_oe_o | output | 1 | Enable for driving `par_o` onto the bus |
| addr_perr_o | output | 1 | One-clock pulse on an address parity mismatch |
| data_perr_o | output | 1 | One-clock pulse on a data parity mismatch |

## Verification
Some properties are checked on every clock. The parity output is compared with the bus bits from one edge earlier. The enable must fall after an idle bus clock, and it may only rise after a clock the tracker marked as driving. Each error pulse must trace back two clocks to an enabled check. Address phases may not repeat in consecutive clocks, and an address error pulse may not stretch. Whether the right side drives and checks in each role and direction, that wait states and STOP# terminations are handled, and that back-to-back frames and reset in the middle of a transaction work, can only be shown by the bench's scripted transactions with deliberately corrupted PAR.

// File: rtl/pcipar_pkg.sv
package pcipar_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_DATA = 1'b1
    } bus_ph_e;

    typedef struct packed {
        bus_ph_e ph;
        logic    wr;
    } trk_s;

    typedef struct packed {
        logic par;
        logic oe;
        logic chk_a;
        logic chk_d;
        logic perr_a;
        logic perr_d;
    } drv_s;

    localparam trk_s TRK_RST = '{ph: PH_IDLE, wr: 1'b0};
    localparam drv_s DRV_RST = '0;

endpackage

// File: rtl/pcipar_xor_tree.sv
module pcipar_xor_tree #(
    parameter int W = 36
) (
    input  logic [W-1:0] bits_i,
    output logic         odd_o
);
    localparam int LV = (W > 1) ? $clog2(W) : 0;
    localparam int P  = 1 << LV;

    for (genvar l = 0; l <= LV; l++) begin : g_lv
        logic [(P >> l)-1:0] v;
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < P; i++) begin : g_in
                if (i < W) begin : g_bit
                    assign v[i] = bits_i[i];
                end else begin : g_pad
                    assign v[i] = 1'b0;
                end
            end
        end else begin : g_node
            for (genvar i = 0; i < (P >> l); i++) begin : g_x
                assign v[i] = g_lv[l-1].v[2*i] ^ g_lv[l-1].v[2*i+1];
            end
        end
    end

    assign odd_o = g_lv[LV].v[0];

endmodule

// File: rtl/pcipar_phase_trk.sv
module pcipar_phase_trk
    import pcipar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic trdy_n,
    input  logic stop_n,
    input  logic cmd_wr,
    output logic addr_ph,
    output logic data_ph,
    output logic dir_wr
);
    trk_s trk_d, trk_q;
    logic bus_idle;
    logic last_done;

    always_comb begin
        trk_d     = trk_q;
        bus_idle  = frame_n && irdy_n;
        addr_ph   = (trk_q.ph == PH_IDLE) && !frame_n;
        data_ph   = (trk_q.ph == PH_DATA) && !bus_idle;
        dir_wr    = trk_q.wr;
        last_done = data_ph && frame_n && !irdy_n && (!trdy_n || !stop_n);
        if (addr_ph) begin
            trk_d.ph = PH_DATA;
            trk_d.wr = cmd_wr;
        end else if ((trk_q.ph == PH_DATA) && (last_done || bus_idle)) begin
            trk_d.ph = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= TRK_RST;
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/pcipar_drv_chk.sv
module pcipar_drv_chk
    import pcipar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic calc_par,
    input  logic par_in,
    input  logic drive_now,
    input  logic chk_addr_now,
    input  logic chk_data_now,
    output logic par_out,
    output logic par_oe,
    output logic addr_perr,
    output logic data_perr
);
    drv_s drv_d, drv_q;
    logic mismatch;

    always_comb begin
        mismatch     = par_in ^ drv_q.par;
        drv_d        = drv_q;
        drv_d.par    = calc_par;
        drv_d.oe     = drive_now;
        drv_d.chk_a  = chk_addr_now;
        drv_d.chk_d  = chk_data_now;
        drv_d.perr_a = drv_q.chk_a && mismatch;
        drv_d.perr_d = drv_q.chk_d && mismatch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= DRV_RST;
        else        drv_q <= drv_d;
    end

    assign par_out   = drv_q.par;
    assign par_oe    = drv_q.oe;
    assign addr_perr = drv_q.perr_a;
    assign data_perr = drv_q.perr_d;

endmodule

// File: rtl/pcipar_top.sv
module pcipar_top #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_n_i,
    input  logic            frame_n_i,
    input  logic            irdy_n_i,
    input  logic            trdy_n_i,
    input  logic            stop_n_i,
    input  logic            mst_own_i,
    input  logic            tgt_sel_i,
    input  logic            par_i,
    output logic            par_o,
    output logic            par_oe_o,
    output logic            addr_perr_o,
    output logic            data_perr_o
);
    localparam int BUS_W = AD_W + BE_W;

    logic bus_odd;
    logic addr_ph, data_ph, dir_wr;
    logic drive_now, chk_addr_now, chk_data_now;

    pcipar_xor_tree #(.W(BUS_W)) u_tree (
        .bits_i ({cbe_n_i, ad_i}),
        .odd_o  (bus_odd)
    );

    pcipar_phase_trk u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n_i),
        .irdy_n  (irdy_n_i),
        .trdy_n  (trdy_n_i),
        .stop_n  (stop_n_i),
        .cmd_wr  (cbe_n_i[0]),
        .addr_ph (addr_ph),
        .data_ph (data_ph),
        .dir_wr  (dir_wr)
    );

    always_comb begin
        drive_now    = (addr_ph && mst_own_i)
                     || (data_ph && ((mst_own_i && dir_wr) || (tgt_sel_i && !dir_wr)));
        chk_addr_now = addr_ph && !mst_own_i;
        chk_data_now = data_ph && ((tgt_sel_i && dir_wr && !irdy_n_i)
                                || (mst_own_i && !dir_wr && !trdy_n_i));
    end

    pcipar_drv_chk u_dc (
        .clk          (clk),
        .rst_n        (rst_n),
        .calc_par     (bus_odd),
        .par_in       (par_i),
        .drive_now    (drive_now),
        .chk_addr_now (chk_addr_now),
        .chk_data_now (chk_data_now),
        .par_out      (par_o),
        .par_oe       (par_oe_o),
        .addr_perr    (addr_perr_o),
        .data_perr    (data_perr_o)
    );

endmodule

// File: rtl/pcipar_sva.sv
module pcipar_sva #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AD_W-1:0] ad,
    input logic [BE_W-1:0] cbe_n,
    input logic            frame_n,
    input logic            irdy_n,
    input logic            par_o,
    input logic            par_oe,
    input logic            addr_perr,
    input logic            data_perr,
    input logic            addr_ph,
    input logic            drive_now,
    input logic            chk_addr_now,
    input logic            chk_data_now
);
    assert_par_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (par_o == ^{$past(cbe_n), $past(ad)}));

    assert_addr_ph_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ph |=> !addr_ph);

    assert_oe_needs_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> $past(drive_now));

    assert_oe_off_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && irdy_n) |=> !par_oe);

    assert_addr_err_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_perr |-> $past(chk_addr_now, 2));

    assert_data_err_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_perr |-> $past(chk_data_now, 2));

    assert_no_dual_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_addr_now |-> !chk_data_now);

    assert_addr_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_perr |=> !addr_perr);

endmodule

bind pcipar_top pcipar_sva #(.AD_W(AD_W), .BE_W(BE_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .ad           (ad_i),
    .cbe_n        (cbe_n_i),
    .frame_n      (frame_n_i),
    .irdy_n       (irdy_n_i),
    .par_o        (par_o),
    .par_oe       (par_oe_o),
    .addr_perr    (addr_perr_o),
    .data_perr    (data_perr_o),
    .addr_ph      (addr_ph),
    .drive_now    (drive_now),
    .chk_addr_now (chk_addr_now),
    .chk_data_now (chk_data_now)
);

// File: tb/sim_pcipar_top.sv
module sim_pcipar_top;

    typedef struct packed {
        logic        f, i, t, s, m, g;
        logic [3:0]  be;
        logic [31:0] ad;
        logic        bad;
        logic        eoe, eae, ede;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{1,1,1,1,0,0,4'hF,32'h0000_0000,0, 0,0,0},
        '{0,1,1,1,1,0,4'h7,32'h1000_0040,0, 0,0,0},
        '{0,0,1,1,1,0,4'h0,32'hDEAD_BEEF,0, 1,0,0},
        '{0,0,0,1,1,0,4'h0,32'hDEAD_BEEF,1, 1,0,0},
        '{1,0,0,1,1,0,4'h3,32'h0123_4567,0, 1,0,0},
        '{1,1,1,1,1,0,4'hF,32'h0000_0000,0, 1,0,0},
        '{1,1,1,1,0,0,4'hF,32'h0000_0000,0, 0,0,0},
        '{0,1,1,1,0,1,4'h3,32'h0000_0CF8,0, 0,0,0},
        '{1,0,1,1,0,1,4'h0,32'h8000_1234,0, 0,0,0},
        '{1,0,0,1,0,1,4'h0,32'h8000_1234,1, 0,0,0},
        '{1,1,1,1,0,1,4'hF,32'h0000_0000,0, 0,0,1},
        '{1,1,1,1,0,0,4'hF,32'h0000_0000,0, 0,0,0},
        '{0,1,1,1,0,1,4'h6,32'h2000_0010,0, 0,0,0},
        '{1,0,1,1,0,1,4'h0,32'h0000_0000,1, 0,0,0},
        '{1,0,0,1,0,1,4'h0,32'hCAFE_F00D,0, 1,1,0},
        '{1,1,1,1,0,1,4'hF,32'h0000_0000,1, 1,0,0},
        '{1,1,1,1,0,0,4'hF,32'h0000_0000,0, 0,0,0},
        '{0,1,1,1,1,0,4'h6,32'h3000_0000,0, 0,0,0},
        '{0,0,1,1,1,0,4'h0,32'h0000_0000,0, 1,0,0},
        '{0,0,0,1,1,0,4'h0,32'h1357_9BDF,0, 0,0,0},
        '{1,0,1,1,1,0,4'h0,32'hFFFF_0000,1, 0,0,0},
        '{1,0,0,1,1,0,4'h0,32'h0F0F_0F0F,1, 0,0,1},
        '{1,1,1,1,1,0,4'hF,32'h0000_0000,0, 0,0,0},
        '{1,1,1,1,0,0,4'hF,32'h0000_0000,0, 0,0,0},
        '{0,1,1,1,0,0,4'h7,32'h4000_0004,0, 0,0,0},
        '{1,0,0,1,0,0,4'h0,32'h1111_1111,1, 0,0,0},
        '{1,1,1,1,0,0,4'hF,32'h0000_0000,1, 0,1,0},
        '{1,1,1,1,0,0,4'hF,32'h0000_0000,0, 0,0,0},
        '{0,1,1,1,0,1,4'h7,32'h5000_0000,0, 0,0,0},
        '{1,0,1,0,0,1,4'h0,32'h7777_7777,0, 0,0,0},
        '{0,1,1,1,0,1,4'h3,32'h0000_03F8,0, 0,0,0},
        '{1,0,0,1,0,1,4'hE,32'h0000_00AA,1, 0,0,0},
        '{1,1,1,1,0,1,4'hF,32'h0000_0000,0, 0,1,0},
        '{1,1,1,1,0,0,4'hF,32'h0000_0000,0, 0,0,0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
    logic        mst = 1'b0, tgt = 1'b0, par_in = 1'b0;
    logic        par_o, par_oe, aerr, derr;
    int          n_chk = 0;
    int          n_bad = 0;
    logic        prevpar;

    always #5 clk = ~clk;

    pcipar_top u0 (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n),
        .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n), .stop_n_i(stop_n),
        .mst_own_i(mst), .tgt_sel_i(tgt), .par_i(par_in),
        .par_o(par_o), .par_oe_o(par_oe), .addr_perr_o(aerr), .data_perr_o(derr)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic put(input logic f, input logic i, input logic t, input logic s,
                       input logic m, input logic g, input logic [3:0] be, input logic [31:0] a,
                       input logic bad);
        frame_n = f; irdy_n = i; trdy_n = t; stop_n = s;
        mst = m; tgt = g; cbe_n = be; ad = a;
        par_in = prevpar ^ bad;
        prevpar = ^{be, a};
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (R1..all) actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        prevpar = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "par_oe in reset", par_oe, 1'b0);
        chk("R8", "addr_perr in reset", aerr, 1'b0);
        chk("R8", "data_perr in reset", derr, 1'b0);
        chk("R8", "par_o in reset", par_o, 1'b0);

        for (int k = 0; k < NV; k++) begin
            logic pexp;
            @(negedge clk);
            if (k == 0) rst_n = 1'b1;
            pexp = prevpar;
            put(VEC[k].f, VEC[k].i, VEC[k].t, VEC[k].s, VEC[k].m, VEC[k].g,
                VEC[k].be, VEC[k].ad, VEC[k].bad);
            #1;
            chk("R3/R4", $sformatf("par_oe vec %0d", k), par_oe, VEC[k].eoe);
            chk("R5/R2", $sformatf("addr_perr vec %0d", k), aerr, VEC[k].eae);
            chk("R6/R7", $sformatf("data_perr vec %0d", k), derr, VEC[k].ede);
            if (k > 0) chk("R1", $sformatf("par_o vec %0d", k), par_o, pexp);
        end

        // R1: parity corner values on an idle bus
        @(negedge clk); put(1,1,1,1,0,0,4'h0,32'h0000_0000,0);
        @(negedge clk); #1 chk("R1", "all zero", par_o, 1'b0);
        put(1,1,1,1,0,0,4'h0,32'h0000_0001,0);
        @(negedge clk); #1 chk("R1", "single one", par_o, 1'b1);
        put(1,1,1,1,0,0,4'hF,32'hFFFF_FFFF,0);
        @(negedge clk); #1 chk("R1", "36 ones", par_o, 1'b0);
        put(1,1,1,1,0,0,4'hE,32'hFFFF_FFFF,0);
        @(negedge clk); #1 chk("R1", "35 ones", par_o, 1'b1);
        put(1,1,1,1,0,0,4'hF,32'h0000_0000,0);

        // R8: reset in the middle of a transaction
        @(negedge clk); put(0,1,1,1,0,0,4'h7,32'h0000_0001,0);
        @(negedge clk); put(1,0,0,1,0,0,4'h0,32'h0000_0000,1); rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R8", "addr_perr after mid reset", aerr, 1'b0);
        chk("R8", "par_oe after mid reset", par_oe, 1'b0);
        chk("R8", "par_o after mid reset", par_o, 1'b0);
        put(1,1,1,1,0,0,4'hF,32'h0000_0000,0);
        @(negedge clk); #1 chk("R8", "addr_perr held in reset", aerr, 1'b0);
        rst_n = 1'b1;
        put(0,1,1,1,0,0,4'h7,32'h0000_0003,0);
        @(negedge clk); put(1,0,0,1,0,0,4'h0,32'h0000_0000,1);
        @(negedge clk); put(1,1,1,1,0,0,4'hF,32'h0000_0000,0);
        #1 chk("R8/R2", "address phase right after reset", aerr, 1'b1);
        @(negedge clk); #1 chk("R9", "addr_perr one clock", aerr, 1'b0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule